// File: doc/BRIEF.md
# Trace Operand and Branch-Target Nibble Serializer

This block sits beside a processor's debug logic and turns selected bus operands and taken-branch targets into a narrow trace stream. Each cycle it can see one bus access (strobe, direction flag, size code and 32-bit data) and one taken branch (strobe and 32-bit target). Two 2-bit mode inputs choose what is traced. The operand mode selects accesses by direction. The branch mode selects how many low bytes of the target are kept.

Every accepted item is queued in a small FIFO, so short bursts are not lost. Each item then goes out on a 4-bit port as one size-marker nibble followed by its data, least-significant nibble first. A valid flag is high on every cycle that carries a nibble. A sticky overflow flag records items dropped because the FIFO had no space.

Top module: `trc_nib_ser`

## Requirements
- R1: Operand mode `data_mode` selects bus accesses by direction (`bus_wr`=1 is a write): 00 traces none, 01 traces writes only, 10 traces reads only, 11 traces both.
- R2: The operand payload length follows `bus_size`: 00 gives 1 byte (`bus_data[7:0]`), 01 gives 2 bytes (`bus_data[15:0]`), and 10 or 11 gives 4 bytes.
- R3: Branch mode `branch_mode` gives the traced target bytes: 00 traces no branch, 01 traces the low 2 bytes of `br_addr`, and 10 or 11 traces the low 3 bytes.
- R4: An item of N bytes is sent as the marker nibble 0x7+N (0x8 to 0xB), then 2N data nibbles with the least-significant first. `trc_vld` is high on every one of those 2N+1 consecutive cycles.
- R5: If the FIFO is empty and the serializer is idle, a strobe sampled on clock edge k makes the marker appear, with `trc_vld` high, right after edge k+1.
- R6: When a branch and a traced bus access are sampled on the same edge, the branch item is sent before the operand item.
- R7: The FIFO holds 8 items. Whether there is space is judged by the occupancy at the start of the cycle. An item that finds no space is dropped, and the branch item takes the last free slot first. Queued items are sent back to back with no idle cycle between them.
- R8: `ovf_flag` goes high after any dropped item. It stays high until a cycle with `ovf_clr` high and no new drop, and then reads 0 after that edge.
- R9: While `trc_vld` is low, `trc_nib` is 0.
- R10: A cycle with `rst` high empties the FIFO, abandons the item being sent and clears `ovf_flag`. After that edge `trc_vld`, `trc_nib` and `ovf_flag` are 0, and nothing queued before the reset is ever sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst | input | 1 | Synchronous active-high reset |
| data_mode | input | 2 | Operand capture mode |
| branch_mode | input | 2 | Branch target byte count mode |
| bus_stb | input | 1 | Bus access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_data | input | 32 | Operand data |
| br_stb | input | 1 | Taken branch present this cycle |
| br_addr | input | 32 | Branch target address |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| trc_nib | output | 4 | Trace nibble |
| trc_vld | output | 1 | Trace nibble valid |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A branch and a traced bus access can arrive on the same edge, and both must enter the FIFO in one cycle with the branch first. The bench applies both strobes together under several mode pairs. It decodes the trace stream independently, splitting it into items by their markers, and checks the order, markers and values of what comes out. A burst of paired strobes then fills the FIFO. The bench checks that only the operand of the final pair is lost, that nine items come out in alternating order, and that the overflow flag is set.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NIB_W  = 4;

    // one queued trace item: byte count minus one and the payload
    typedef struct packed {
        logic [1:0]        nb_m1;
        logic [DATA_W-1:0] val;
    } trc_item_t;

    localparam int unsigned ITEM_W = $bits(trc_item_t);
    localparam logic [1:0]  MARK_HI = 2'b10;
endpackage

// File: rtl/trc_filter.sv
module trc_filter
    import trc_pkg::*;
(
    input  logic [1:0]        data_mode,
    input  logic [1:0]        branch_mode,
    input  logic              bus_stb,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              br_stb,
    input  logic [DATA_W-1:0] br_addr,
    output logic              br_ok,
    output trc_item_t         br_item,
    output logic              op_ok,
    output trc_item_t         op_item
);
    always_comb begin
        // operand: bit 0 of the mode enables writes, bit 1 enables reads
        op_ok = bus_stb && (bus_wr ? data_mode[0] : data_mode[1]);
        case (bus_size)
            2'b00: begin
                op_item.nb_m1 = 2'd0;
                op_item.val   = {24'b0, bus_data[7:0]};
            end
            2'b01: begin
                op_item.nb_m1 = 2'd1;
                op_item.val   = {16'b0, bus_data[15:0]};
            end
            default: begin
                op_item.nb_m1 = 2'd3;
                op_item.val   = bus_data;
            end
        endcase

        br_ok = br_stb && (branch_mode != 2'b00);
        if (branch_mode[1]) begin
            br_item.nb_m1 = 2'd2;
            br_item.val   = {8'b0, br_addr[23:0]};
        end else begin
            br_item.nb_m1 = 2'd1;
            br_item.val   = {16'b0, br_addr[15:0]};
        end
    end
endmodule

// File: rtl/trc_fifo.sv
// Two-write, one-read queue; DEPTH must be a power of two.
module trc_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push0,
    input  logic [W-1:0] din0,
    input  logic         push1,
    input  logic [W-1:0] din1,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         drop
);
    localparam int          AW     = $clog2(DEPTH);
    localparam logic [AW:0] FULL_C = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t    st_q, st_d;
    logic [AW:0] space;
    logic        acc0, acc1;

    always_comb begin
        st_d  = st_q;
        space = FULL_C - st_q.cnt;
        // slot 0 (the branch) claims space before slot 1
        acc0  = push0 && (space != '0);
        acc1  = push1 && (space > {{AW{1'b0}}, acc0});
        if (acc0) st_d.mem[st_q.wp] = din0;
        if (acc1) st_d.mem[st_q.wp + AW'(acc0)] = din1;
        st_d.wp  = st_q.wp + AW'(acc0) + AW'(acc1);
        if (pop) st_d.rp = st_q.rp + AW'(1);
        st_d.cnt = st_q.cnt + (AW+1)'(acc0) + (AW+1)'(acc1) - (AW+1)'(pop);
        drop  = (push0 && !acc0) || (push1 && !acc1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL_C); // R7
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R7
    AST_DROP_ONLY_SHORT: assert property (@(posedge clk) disable iff (rst)
        drop |-> (space < (AW+1)'(2))); // R7
endmodule

// File: rtl/trc_shift.sv
module trc_shift
    import trc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  trc_item_t        head,
    input  logic             empty,
    output logic             pop,
    output logic [NIB_W-1:0] trc_nib,
    output logic             trc_vld
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [3:0]        left;
        logic [NIB_W-1:0]  nib;
        logic              vld;
    } sh_st_t;

    sh_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (st_q.left != 4'd0) begin
            st_d.nib  = st_q.sh[NIB_W-1:0];
            st_d.sh   = {{NIB_W{1'b0}}, st_q.sh[DATA_W-1:NIB_W]};
            st_d.left = st_q.left - 4'd1;
            st_d.vld  = 1'b1;
        end else if (!empty) begin
            pop       = 1'b1;
            st_d.nib  = {MARK_HI, head.nb_m1};
            st_d.sh   = head.val;
            st_d.left = {1'b0, head.nb_m1, 1'b0} + 4'd2;
            st_d.vld  = 1'b1;
        end else begin
            st_d.nib  = '0;
            st_d.sh   = '0;
            st_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign trc_nib = st_q.nib;
    assign trc_vld = st_q.vld;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !trc_vld |-> (trc_nib == '0)); // R9
    AST_MARKER_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(trc_vld) |-> (trc_nib[3:2] == MARK_HI)); // R4
    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.left != 4'd0) |=> trc_vld); // R4
endmodule

// File: rtl/trc_nib_ser.sv
module trc_nib_ser
    import trc_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  data_mode,
    input  logic [1:0]  branch_mode,
    input  logic        bus_stb,
    input  logic        bus_wr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_data,
    input  logic        br_stb,
    input  logic [31:0] br_addr,
    input  logic        ovf_clr,
    output logic [3:0]  trc_nib,
    output logic        trc_vld,
    output logic        ovf_flag
);
    trc_item_t br_item, op_item, head;
    logic      br_ok, op_ok, fifo_empty, fifo_drop, fifo_pop;
    logic      ovf_q, ovf_d;

    trc_filter u_filt (
        .data_mode   (data_mode),
        .branch_mode (branch_mode),
        .bus_stb     (bus_stb),
        .bus_wr      (bus_wr),
        .bus_size    (bus_size),
        .bus_data    (bus_data),
        .br_stb      (br_stb),
        .br_addr     (br_addr),
        .br_ok       (br_ok),
        .br_item     (br_item),
        .op_ok       (op_ok),
        .op_item     (op_item)
    );

    // branch on slot 0 so it is queued ahead of a same-cycle operand
    trc_fifo #(.DEPTH(FIFO_DEPTH), .W(ITEM_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push0 (br_ok),
        .din0  (br_item),
        .push1 (op_ok),
        .din1  (op_item),
        .pop   (fifo_pop),
        .dout  (head),
        .empty (fifo_empty),
        .drop  (fifo_drop)
    );

    trc_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .head    (head),
        .empty   (fifo_empty),
        .pop     (fifo_pop),
        .trc_nib (trc_nib),
        .trc_vld (trc_vld)
    );

    always_comb begin
        ovf_d = fifo_drop || (ovf_q && !ovf_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= ovf_d;
    end

    assign ovf_flag = ovf_q;

    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        fifo_drop |=> ovf_flag); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!trc_vld && trc_nib == 4'd0 && !ovf_flag)); // R10
endmodule

// File: tb/sim_trc_nib_ser.sv
`timescale 1ns/100ps
module sim_trc_nib_ser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  data_mode = 2'b00, branch_mode = 2'b00;
    logic        bus_stb = 1'b0, bus_wr = 1'b0, br_stb = 1'b0, ovf_clr = 1'b0;
    logic [1:0]  bus_size = 2'b00;
    logic [31:0] bus_data = 32'hA1B2C3D4;
    logic [31:0] br_addr  = 32'h12345678;
    logic [3:0]  trc_nib;
    logic        trc_vld, ovf_flag;

    always #2.5 clk = ~clk;

    trc_nib_ser u0 (
        .clk(clk), .rst(rst), .data_mode(data_mode), .branch_mode(branch_mode),
        .bus_stb(bus_stb), .bus_wr(bus_wr), .bus_size(bus_size), .bus_data(bus_data),
        .br_stb(br_stb), .br_addr(br_addr), .ovf_clr(ovf_clr),
        .trc_nib(trc_nib), .trc_vld(trc_vld), .ovf_flag(ovf_flag)
    );

    int total = 0, bad = 0;
    int got_n = 0, mon_left = 0, mon_pos = 0, idle_bad = 0, gap_bad = 0;
    logic [3:0]  got_m [16];
    logic [31:0] got_v [16];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // independent stream decoder: markers frame items, data nibbles LSB first
    always @(negedge clk) begin
        if (rst) begin
            mon_left = 0;
        end else if (trc_vld) begin
            if (mon_left == 0) begin
                if (trc_nib[3:2] != 2'b10) begin
                    total++; bad++;
                    $display("FAIL R4 actual=%0h expected=marker 8..b", trc_nib);
                end else if (got_n < 16) begin
                    got_m[got_n] = trc_nib;
                    got_v[got_n] = 32'd0;
                    mon_left = 2 * (int'(trc_nib[1:0]) + 1);
                    mon_pos = 0;
                end
            end else begin
                got_v[got_n] = got_v[got_n] | (32'(trc_nib) << (4 * mon_pos));
                mon_pos++;
                mon_left--;
                if (mon_left == 0) got_n++;
            end
        end else begin
            if (trc_nib != 4'd0) idle_bad++;
            if (mon_left != 0) gap_bad++;
        end
    end

    typedef struct packed {
        logic [1:0]  dm;
        logic [1:0]  bm;
        logic        bs;
        logic        wr;
        logic [1:0]  sz;
        logic        bb;
        logic [1:0]  n;
        logic [3:0]  m0;
        logic [31:0] v0;
        logic [3:0]  m1;
        logic [31:0] v1;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 2'd1, 4'h8, 32'h000000D4, 4'h0, 32'h0},
        '{2'b01, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 2'd0, 4'h0, 32'h0,        4'h0, 32'h0},
        '{2'b10, 2'b00, 1'b1, 1'b0, 2'b01, 1'b0, 2'd1, 4'h9, 32'h0000C3D4, 4'h0, 32'h0},
        '{2'b10, 2'b00, 1'b1, 1'b1, 2'b10, 1'b0, 2'd0, 4'h0, 32'h0,        4'h0, 32'h0},
        '{2'b11, 2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 2'd1, 4'hB, 32'hA1B2C3D4, 4'h0, 32'h0},
        '{2'b11, 2'b00, 1'b1, 1'b1, 2'b11, 1'b0, 2'd1, 4'hB, 32'hA1B2C3D4, 4'h0, 32'h0},
        '{2'b00, 2'b00, 1'b1, 1'b1, 2'b10, 1'b0, 2'd0, 4'h0, 32'h0,        4'h0, 32'h0},
        '{2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 2'd1, 4'h9, 32'h00005678, 4'h0, 32'h0},
        '{2'b00, 2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 2'd1, 4'hA, 32'h00345678, 4'h0, 32'h0},
        '{2'b00, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 2'd1, 4'hA, 32'h00345678, 4'h0, 32'h0},
        '{2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 2'd0, 4'h0, 32'h0,        4'h0, 32'h0},
        '{2'b11, 2'b01, 1'b1, 1'b1, 2'b10, 1'b1, 2'd2, 4'h9, 32'h00005678, 4'hB, 32'hA1B2C3D4},
        '{2'b11, 2'b00, 1'b1, 1'b0, 2'b00, 1'b1, 2'd1, 4'h8, 32'h000000D4, 4'h0, 32'h0},
        '{2'b00, 2'b11, 1'b1, 1'b1, 2'b10, 1'b1, 2'd1, 4'hA, 32'h00345678, 4'h0, 32'h0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        chk(idle_bad == 0, "R9 idle nibble", 32'(idle_bad), 32'd0);
        chk(gap_bad == 0, "R4 R7 gap inside item", 32'(gap_bad), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) tick();
        // R10 reset state
        chk(!trc_vld && trc_nib == 4'd0 && !ovf_flag, "R10 reset state",
            {29'd0, trc_vld, ovf_flag, |trc_nib}, 32'd0);
        rst = 1'b0;
        tick();

        // R5 latency and R4 nibble order on a write byte
        data_mode = 2'b01; bus_wr = 1'b1; bus_size = 2'b00; bus_stb = 1'b1;
        tick();                       // edge k samples the strobe
        bus_stb = 1'b0;
        chk(!trc_vld, "R5 no output after edge k", {31'd0, trc_vld}, 32'd0);
        tick();
        chk(trc_vld && trc_nib == 4'h8, "R5 marker after edge k+1", {27'd0, trc_vld, trc_nib}, 32'h18);
        tick();
        chk(trc_nib == 4'h4, "R4 low nibble first", 32'(trc_nib), 32'h4);
        tick();
        chk(trc_nib == 4'hD, "R4 high nibble second", 32'(trc_nib), 32'hD);
        repeat (5) tick();
        got_n = 0;

        // table of mode/strobe vectors
        for (int i = 0; i < NV; i++) begin
            tag = (i < 7) ? "R1 R2" : (i < 11) ? "R3" : "R6";
            data_mode = VEC[i].dm; branch_mode = VEC[i].bm;
            bus_wr = VEC[i].wr; bus_size = VEC[i].sz;
            bus_stb = VEC[i].bs; br_stb = VEC[i].bb;
            tick();
            bus_stb = 1'b0; br_stb = 1'b0;
            repeat (30) tick();
            chk(got_n == int'(VEC[i].n), $sformatf("%s vec%0d count", tag, i), 32'(got_n), 32'(VEC[i].n));
            if (VEC[i].n >= 2'd1 && got_n >= 1) begin
                chk(got_m[0] == VEC[i].m0, $sformatf("%s vec%0d marker0", tag, i), 32'(got_m[0]), 32'(VEC[i].m0));
                chk(got_v[0] == VEC[i].v0, $sformatf("%s vec%0d data0", tag, i), got_v[0], VEC[i].v0);
            end
            if (VEC[i].n == 2'd2 && got_n >= 2) begin
                chk(got_m[1] == VEC[i].m1, $sformatf("%s vec%0d marker1", tag, i), 32'(got_m[1]), 32'(VEC[i].m1));
                chk(got_v[1] == VEC[i].v1, $sformatf("%s vec%0d data1", tag, i), got_v[1], VEC[i].v1);
            end
            got_n = 0;
        end

        // R7 R8 overflow: five paired strobes offer ten items, nine fit
        data_mode = 2'b11; branch_mode = 2'b11; bus_wr = 1'b1; bus_size = 2'b10;
        chk(!ovf_flag, "R8 flag low before burst", {31'd0, ovf_flag}, 32'd0);
        bus_stb = 1'b1; br_stb = 1'b1;
        repeat (5) tick();
        bus_stb = 1'b0; br_stb = 1'b0;
        chk(ovf_flag, "R8 flag set after drop", {31'd0, ovf_flag}, 32'd1);
        repeat (100) tick();
        chk(got_n == 9, "R7 items kept in burst", 32'(got_n), 32'd9);
        chk(got_m[7] == 4'hB && got_m[8] == 4'hA, "R7 branch took last slot",
            {24'd0, got_m[7], got_m[8]}, 32'hBA);
        chk(got_m[0] == 4'hA && got_m[1] == 4'hB, "R6 burst order",
            {24'd0, got_m[0], got_m[1]}, 32'hAB);
        chk(ovf_flag, "R8 flag sticky", {31'd0, ovf_flag}, 32'd1);
        ovf_clr = 1'b1;
        tick();
        ovf_clr = 1'b0;
        chk(!ovf_flag, "R8 flag cleared", {31'd0, ovf_flag}, 32'd0);
        got_n = 0;

        // R10 reset mid-item with a full queue
        bus_stb = 1'b1; br_stb = 1'b1;
        repeat (5) tick();
        bus_stb = 1'b0; br_stb = 1'b0;
        repeat (3) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(!trc_vld && trc_nib == 4'd0 && !ovf_flag, "R10 abort and clear",
            {27'd0, trc_vld, ovf_flag, trc_nib[2:0] | {2'd0, trc_nib[3]}}, 32'd0);
        got_n = 0;
        repeat (40) tick();
        chk(got_n == 0 && !trc_vld, "R10 queue emptied", 32'(got_n), 32'd0);

        finish_up();
    end
endmodule